// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the addressing layer of a slave on a single-wire, wired-AND bus. It sits above a time-slot engine that already turns line activity into three strobes: a received bit, a request for the next bit to drive, and a bus reset that follows the reset and presence exchange. The block carries a fixed 64-bit identity. After each bus reset it collects one 8-bit ROM command and then runs one of four selection procedures: it sends out its identity, compares a received identity, takes part in a bitwise search, or accepts the command without any identity exchange. When the procedure succeeds it raises a flag that hands the bus to the memory command layer. When it fails, it stays silent until the next bus reset.

The identity is formed when the block is elaborated. The family code fills the low byte and the serial number fills the next 48 bits. The top byte is a CRC computed over those 56 bits. The transmit output is the bit the slave wants on the line, and 1 means released. Several slaves can therefore be ANDed together onto one line.

Top module: `owrom_net_layer`

## Requirements
- R1: After rst_n and after every bus reset, tx_bit is 1 and mem_en is 0. While no strobe arrives, neither output changes.
- R2: A ROM command is the first 8 bits received after a bus reset, least significant bit first. The recognised codes are 33h (send identity), 55h (compare identity), F0h (search) and CCh (direct access).
- R3: After 33h, tx_bit shows identity bit 0 first. Each tx_req advances it by one bit. The consumption of bit 63 raises mem_en.
- R4: After 55h the next 64 received bits are compared with the identity, bit 0 first. mem_en rises after bit 63 only if every bit matched. At the first mismatch the slave goes silent and stays so until a bus reset.
- R5: After F0h, each identity bit takes three slots. tx_bit shows the bit, then after one tx_req its complement, then after a second tx_req it shows 1 while the slave waits for a received bit. A received bit that differs from the identity bit sends the slave silent until a bus reset.
- R6: A search in which all 64 received choices match the identity raises mem_en after the last choice.
- R7: After CCh, mem_en is 1 in the cycle following the eighth command bit. Once mem_en is set, it stays set until a bus reset.
- R8: Identity bits 7:0 hold the family code (default 09h) and bits 55:8 hold the serial number. Bits 63:56 hold the CRC of bits 55:0, using x^8+x^5+x^4+1 with a zero start and least significant bit first. The CRC of all 64 bits is therefore zero.
- R9: Any other command code sends the slave silent: tx_bit 1, mem_en 0, and all later bits and requests are ignored until a bus reset.
- R10: A bus reset in any state returns the slave to command collection and clears mem_en. When it coincides with a received bit or a tx_req, that bit or request has no effect.
- R11: A tx_req in a state that does not transmit (command collection, compare, search wait slot, memory access, silent) changes nothing.
- R12: Two slaves whose tx_bit are ANDed onto one line can both be found by a master running the standard search over repeated passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle strobe: a reset/presence exchange has completed |
| rx_valid | input | 1 | One-cycle strobe: rx_bit holds a bit written by the master |
| rx_bit | input | 1 | Received bit value |
| tx_req | input | 1 | One-cycle strobe: the current tx_bit has been used, advance |
| tx_bit | output | 1 | Bit to drive in the next read slot (1 = released) |
| mem_en | output | 1 | Selection succeeded; memory commands may follow |

## Verification
The one collision the interface allows is a bus reset in the same cycle as a received bit or a transmit request. The bench provokes the sharpest version of it. It sends a compare command with 63 matching bits, then presents the 64th matching bit together with the bus reset. The design must leave mem_en low. It must also treat the colliding bit as never received, which the bench judges by requiring a full eight further bits before a following direct-access command raises mem_en. A behavioural model of two slaves, compared every cycle, judges every other cycle of the run.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

   localparam int OP_W = 8;

   localparam logic [OP_W-1:0] OP_READ   = 8'h33;
   localparam logic [OP_W-1:0] OP_MATCH  = 8'h55;
   localparam logic [OP_W-1:0] OP_SEARCH = 8'hF0;
   localparam logic [OP_W-1:0] OP_SKIP   = 8'hCC;

   typedef enum logic [2:0] {
      ST_CMD,     // collecting the ROM command
      ST_READ,    // sending identity bits
      ST_MATCH,   // comparing received identity bits
      ST_SB,      // search: true bit
      ST_SC,      // search: complement bit
      ST_SR,      // search: waiting for the master's choice
      ST_MEM,     // selected, memory layer owns the bus
      ST_IDLE     // deselected until bus reset
   } ow_state_e;

   // one LSB-first step of the x^8+x^5+x^4+1 CRC (reflected form)
   function automatic logic [7:0] crc_step(input logic [7:0] c, input logic b);
      logic fb;
      fb = c[0] ^ b;
      crc_step = {1'b0, c[7:1]} ^ (fb ? 8'h8C : 8'h00);
   endfunction

endpackage

// File: rtl/owrom_crc_chain.sv
module owrom_crc_chain #(
   parameter int N = 56
)(
   input  logic [N-1:0] din,
   output logic [7:0]   crc
);

   logic [7:0] stage [N+1];

   assign stage[0] = '0;

   for (genvar i = 0; i < N; i++) begin : g_step
      assign stage[i+1] = owrom_pkg::crc_step(stage[i], din[i]);
   end

   assign crc = stage[N];

endmodule

// File: rtl/owrom_cmd_rx.sv
module owrom_cmd_rx #(
   parameter int W = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift_en,
   input  logic         bit_in,
   output logic         done,
   output logic [W-1:0] code
);

   localparam int CW = (W > 2) ? $clog2(W) : 1;

   logic [CW-1:0] cnt;
   logic [W-2:0]  sreg;

   assign code = {bit_in, sreg};
   assign done = shift_en && (cnt == CW'(W-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sreg <= '0;
      end else if (clr) begin
         cnt  <= '0;
         sreg <= '0;
      end else if (shift_en) begin
         sreg <= code[W-1:1];
         cnt  <= done ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/owrom_bit_cursor.sv
module owrom_bit_cursor #(
   parameter int LEN = 64
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     step,
   output logic [$clog2(LEN)-1:0]   idx,
   output logic                     at_last
);

   localparam int IW = $clog2(LEN);

   assign at_last = (idx == IW'(LEN-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (clr)
         idx <= '0;
      else if (step && !at_last)
         idx <= idx + 1'b1;
   end

endmodule

// File: rtl/owrom_net_layer.sv
module owrom_net_layer #(
   parameter int               FAM_W  = 8,
   parameter int               SER_W  = 48,
   parameter int               CRC_W  = 8,
   parameter logic [FAM_W-1:0] FAMILY = 8'h09,
   parameter logic [SER_W-1:0] SERIAL = 48'h0000_0000_0001
)(
   input  logic clk,
   input  logic rst_n,
   input  logic bus_reset,
   input  logic rx_valid,
   input  logic rx_bit,
   input  logic tx_req,
   output logic tx_bit,
   output logic mem_en
);
   import owrom_pkg::*;

   localparam int PAY_W = FAM_W + SER_W;
   localparam int ID_W  = PAY_W + CRC_W;
   localparam int IDX_W = $clog2(ID_W);

   if (CRC_W != 8) begin : g_bad_crc
      $error("owrom_net_layer: CRC_W must be 8");
   end
   if (FAM_W < 1 || SER_W < 1) begin : g_bad_fields
      $error("owrom_net_layer: identity fields must be non-empty");
   end
   if (OP_W < 2) begin : g_bad_op
      $error("owrom_net_layer: command width too small");
   end

   // identity: payload fixed at elaboration, CRC from an unrolled chain
   localparam logic [PAY_W-1:0] PAYLOAD = {SERIAL, FAMILY};
   logic [CRC_W-1:0] id_crc;
   logic [ID_W-1:0]  id_word;

   owrom_crc_chain #(.N(PAY_W)) u_crc (
      .din (PAYLOAD),
      .crc (id_crc)
   );
   assign id_word = {id_crc, PAYLOAD};

   ow_state_e state, nxt;

   logic             cmd_done;
   logic [OP_W-1:0]  cmd_code;
   logic             cmd_clr, cmd_shift;
   logic [IDX_W-1:0] idx;
   logic             at_last, cur_clr, cur_step;
   logic             id_bit;

   assign cmd_clr   = bus_reset || (state != ST_CMD);
   assign cmd_shift = rx_valid && !bus_reset && (state == ST_CMD);

   owrom_cmd_rx #(.W(OP_W)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cmd_clr),
      .shift_en (cmd_shift),
      .bit_in   (rx_bit),
      .done     (cmd_done),
      .code     (cmd_code)
   );

   assign cur_clr = bus_reset || (state == ST_CMD);

   owrom_bit_cursor #(.LEN(ID_W)) u_cur (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cur_clr),
      .step    (cur_step),
      .idx     (idx),
      .at_last (at_last)
   );

   assign id_bit = id_word[idx];

   always_comb begin
      nxt      = state;
      cur_step = 1'b0;
      if (bus_reset) begin
         nxt = ST_CMD;
      end else begin
         unique case (state)
            ST_CMD: begin
               if (cmd_done) begin
                  unique case (cmd_code)
                     OP_READ:   nxt = ST_READ;
                     OP_MATCH:  nxt = ST_MATCH;
                     OP_SEARCH: nxt = ST_SB;
                     OP_SKIP:   nxt = ST_MEM;
                     default:   nxt = ST_IDLE;
                  endcase
               end
            end
            ST_READ: begin
               if (tx_req) begin
                  if (at_last) nxt = ST_MEM;
                  else         cur_step = 1'b1;
               end
            end
            ST_MATCH: begin
               if (rx_valid) begin
                  if (rx_bit != id_bit) nxt = ST_IDLE;
                  else if (at_last)     nxt = ST_MEM;
                  else                  cur_step = 1'b1;
               end
            end
            ST_SB: if (tx_req) nxt = ST_SC;
            ST_SC: if (tx_req) nxt = ST_SR;
            ST_SR: begin
               if (rx_valid) begin
                  if (rx_bit != id_bit) nxt = ST_IDLE;
                  else if (at_last)     nxt = ST_MEM;
                  else begin
                     cur_step = 1'b1;
                     nxt      = ST_SB;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_CMD;
      else        state <= nxt;
   end

   always_comb begin
      unique case (state)
         ST_READ, ST_SB: tx_bit = id_bit;
         ST_SC:          tx_bit = ~id_bit;
         default:        tx_bit = 1'b1;
      endcase
   end

   assign mem_en = (state == ST_MEM);

endmodule

// File: rtl/owrom_net_layer_chk.sv
module owrom_net_layer_chk (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_reset,
   input logic                 rx_valid,
   input logic                 tx_req,
   input logic                 tx_bit,
   input logic                 mem_en,
   input owrom_pkg::ow_state_e state
);
   import owrom_pkg::*;

   // R10: bus reset always lands in command collection with outputs released
   a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> (!mem_en && tx_bit && state == ST_CMD));

   // R9: a deselected slave stays deselected until bus reset
   a_r9_idle_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !bus_reset) |=> (state == ST_IDLE));

   // R6: selection only follows a received bit or a consumed transmit bit
   a_r6_mem_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_en) |-> $past(rx_valid || tx_req));

   // R5: the slot after the true bit carries its complement
   a_r5_complement: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SB && tx_req && !bus_reset) |=> (tx_bit != $past(tx_bit)));

   // R1: without strobes, outputs hold
   a_r1_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_req && !rx_valid && !bus_reset) |=> ($stable(tx_bit) && $stable(mem_en)));

   // R7: selection holds until bus reset
   a_r7_mem_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !bus_reset) |=> mem_en);

endmodule

bind owrom_net_layer owrom_net_layer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_reset (bus_reset),
   .rx_valid  (rx_valid),
   .tx_req    (tx_req),
   .tx_bit    (tx_bit),
   .mem_en    (mem_en),
   .state     (state)
);

// File: tb/owrom_net_layer_bench.sv
module owrom_net_layer_bench;

   localparam logic [7:0]  FAM   = 8'h09;
   localparam logic [47:0] SER_A = 48'h3A51_0C7E_92D4;
   localparam logic [47:0] SER_B = 48'h0B62_9F13_44E8;

   function automatic logic [7:0] ref_crc(input logic [63:0] v, input int n);
      logic [7:0] c;
      c = 8'h00;
      for (int i = 0; i < n; i++) begin
         if (c[0] ^ v[i]) c = (c >> 1) ^ 8'h8C;
         else             c = c >> 1;
      end
      return c;
   endfunction

   function automatic logic [63:0] mk_id(input logic [47:0] ser);
      logic [63:0] p;
      p = {8'h00, ser, FAM};
      return {ref_crc(p, 56), ser, FAM};
   endfunction

   localparam logic [63:0] ID_A = mk_id(SER_A);
   localparam logic [63:0] ID_B = mk_id(SER_B);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_reset = 1'b0;
   logic rx_valid = 1'b0;
   logic rx_bit = 1'b0;
   logic tx_req = 1'b0;
   logic tx_a, tx_b, mem_a, mem_b;
   logic line;

   assign line = tx_a & tx_b;

   always #2 clk = ~clk;

   owrom_net_layer #(.FAMILY(FAM), .SERIAL(SER_A)) u_owrom_net_layer (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
      .rx_bit(rx_bit), .tx_req(tx_req), .tx_bit(tx_a), .mem_en(mem_a));

   owrom_net_layer #(.FAMILY(FAM), .SERIAL(SER_B)) u_owrom_net_layer_b (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
      .rx_bit(rx_bit), .tx_req(tx_req), .tx_bit(tx_b), .mem_en(mem_b));

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [63:0] act,
                      input logic [63:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference of both slaves ----------------
   // mode: 0 cmd, 1 send id, 2 compare, 3 true bit, 4 complement, 5 choice, 6 selected, 7 silent
   int         m_mode [2];
   int         m_pos  [2];
   int         m_cnt  [2];
   logic [7:0] m_cb   [2];

   function automatic logic [63:0] id_of(input int s);
      return (s == 0) ? ID_A : ID_B;
   endfunction

   function automatic logic exp_tx(input int s);
      logic [63:0] me;
      me = id_of(s);
      case (m_mode[s])
         1, 3:    return me[m_pos[s]];
         4:       return ~me[m_pos[s]];
         default: return 1'b1;
      endcase
   endfunction

   function automatic string tag_of(input int s);
      case (m_mode[s])
         0:       return "R2";
         1:       return "R3";
         2:       return "R4";
         3, 4, 5: return "R5";
         6:       return "R7";
         default: return "R9";
      endcase
   endfunction

   always @(posedge clk) begin
      for (int s = 0; s < 2; s++) begin
         logic [63:0] me;
         me = id_of(s);
         if (!rst_n || bus_reset) begin
            m_mode[s] = 0; m_cnt[s] = 0; m_cb[s] = 8'h00; m_pos[s] = 0;
         end else begin
            case (m_mode[s])
               0: if (rx_valid) begin
                     m_cb[s] = {rx_bit, m_cb[s][7:1]};
                     m_cnt[s]++;
                     if (m_cnt[s] == 8) begin
                        m_cnt[s] = 0; m_pos[s] = 0;
                        if      (m_cb[s] == 8'h33) m_mode[s] = 1;
                        else if (m_cb[s] == 8'h55) m_mode[s] = 2;
                        else if (m_cb[s] == 8'hF0) m_mode[s] = 3;
                        else if (m_cb[s] == 8'hCC) m_mode[s] = 6;
                        else                       m_mode[s] = 7;
                     end
                  end
               1: if (tx_req) begin
                     if (m_pos[s] == 63) m_mode[s] = 6; else m_pos[s]++;
                  end
               2: if (rx_valid) begin
                     if (rx_bit != me[m_pos[s]]) m_mode[s] = 7;
                     else if (m_pos[s] == 63)    m_mode[s] = 6;
                     else                        m_pos[s]++;
                  end
               3: if (tx_req) m_mode[s] = 4;
               4: if (tx_req) m_mode[s] = 5;
               5: if (rx_valid) begin
                     if (rx_bit != me[m_pos[s]]) m_mode[s] = 7;
                     else if (m_pos[s] == 63)    m_mode[s] = 6;
                     else begin m_pos[s]++; m_mode[s] = 3; end
                  end
               default: ;
            endcase
         end
      end
   end

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(tag_of(0), 64'(tx_a),  64'(exp_tx(0)),         "A tx_bit vs model");
         chk(tag_of(0), 64'(mem_a), 64'(m_mode[0] == 6),    "A mem_en vs model");
         chk(tag_of(1), 64'(tx_b),  64'(exp_tx(1)),         "B tx_bit vs model");
         chk(tag_of(1), 64'(mem_b), 64'(m_mode[1] == 6),    "B mem_en vs model");
      end
   end

   // ---------------- stimulus primitives ----------------
   task automatic strobe_reset();
      @(negedge clk); bus_reset = 1'b1;
      @(negedge clk); bus_reset = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); rx_valid = 1'b1; rx_bit = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) send_bit(v[i]);
   endtask

   task automatic read_line(output logic b);
      @(negedge clk); b = line; tx_req = 1'b1;
      @(negedge clk); tx_req = 1'b0;
   endtask

   task automatic read_a(output logic b);
      @(negedge clk); b = tx_a; tx_req = 1'b1;
      @(negedge clk); tx_req = 1'b0;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      finish_run();
   end

   // ---------------- scenarios ----------------
   initial begin
      logic [63:0] cap;
      logic        b, c, d;
      logic [63:0] prev, cur;
      logic [63:0] found [4];
      int          nfound, last_disc, last_zero;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 64'(tx_a),  64'd1, "tx released after reset");
      chk("R1", 64'(mem_a), 64'd0, "not selected after reset");

      // R3 / R8: send identity, observed on slave A's own output
      strobe_reset();
      send_byte(8'h33);
      for (int i = 0; i < 64; i++) begin read_a(b); cap[i] = b; end
      chk("R3", cap, ID_A, "identity sent LSB first");
      chk("R8", 64'(cap[7:0]), 64'(FAM), "family code in low byte");
      chk("R8", 64'(ref_crc(cap, 64)), 64'd0, "CRC over full identity");
      chk("R3", 64'(mem_a), 64'd1, "selected after identity sent");

      // R10: reset out of the selected state
      strobe_reset();
      chk("R10", 64'(mem_a), 64'd0, "reset clears selection");

      // R7: direct access
      send_byte(8'hCC);
      chk("R7", 64'(mem_a), 64'd1, "A selected by direct access");
      chk("R7", 64'(mem_b), 64'd1, "B selected by direct access");
      read_line(b);
      chk("R11", 64'(line), 64'd1, "request ignored while selected");

      // R4: compare identity A
      strobe_reset();
      send_byte(8'h55);
      for (int i = 0; i < 64; i++) begin
         send_bit(ID_A[i]);
         if (i == 0) begin
            read_line(b);
            chk("R11", 64'(line), 64'd1, "request ignored while comparing");
         end
      end
      chk("R4", 64'(mem_a), 64'd1, "matching slave selected");
      chk("R4", 64'(mem_b), 64'd0, "other slave not selected");

      // R10: reset coinciding with the last compare bit
      strobe_reset();
      send_byte(8'h55);
      for (int i = 0; i < 63; i++) send_bit(ID_A[i]);
      @(negedge clk); rx_valid = 1'b1; rx_bit = ID_A[63]; bus_reset = 1'b1;
      @(negedge clk); rx_valid = 1'b0; bus_reset = 1'b0;
      chk("R10", 64'(mem_a), 64'd0, "reset wins over final bit");
      for (int i = 0; i < 7; i++) send_bit(1'b0 ^ 8'hCC >> i & 1'b1 ? 1'b1 : 1'b0);
      chk("R10", 64'(mem_a), 64'd0, "colliding bit not counted as command");
      send_bit(1'b1);
      chk("R10", 64'(mem_a), 64'd1, "command after collision takes 8 bits");

      // R9: unknown command
      strobe_reset();
      send_byte(8'h42);
      for (int i = 0; i < 4; i++) begin
         read_line(b);
         chk("R9", 64'(b), 64'd1, "silent slave keeps line released");
      end
      send_byte(8'hCC);
      chk("R9", 64'(mem_a), 64'd0, "silent slave ignores later command");
      chk("R9", 64'(mem_b), 64'd0, "silent slave B ignores later command");

      // R12 / R5 / R6: search over the shared line
      nfound = 0; last_disc = -1; prev = '0;
      do begin
         strobe_reset();
         send_byte(8'hF0);
         last_zero = -1;
         for (int i = 0; i < 64; i++) begin
            read_line(b);
            read_line(c);
            chk("R5", 64'(b & c), 64'd0, "bit and complement not both released");
            if (!b && !c) begin
               if (i == last_disc)     d = 1'b1;
               else if (i > last_disc) d = 1'b0;
               else                    d = prev[i];
               if (!d) last_zero = i;
            end else begin
               d = b;
            end
            send_bit(d);
            cur[i] = d;
         end
         chk("R6", 64'(mem_a | mem_b), 64'd1, "search winner selected");
         chk("R5", 64'(mem_a & mem_b), 64'd0, "search loser dropped out");
         found[nfound] = cur;
         nfound++;
         prev = cur;
         last_disc = last_zero;
      end while (last_disc != -1 && nfound < 4);
      chk("R12", 64'(nfound), 64'd2, "search pass count");
      chk("R12", 64'(((found[0] == ID_A) && (found[1] == ID_B)) ||
                     ((found[0] == ID_B) && (found[1] == ID_A))), 64'd1,
          "both identities discovered");

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule